// File: doc/BRIEF.md
# SuperSpeed Lane Power-Up Sequencer

This block walks one SuperSpeed PHY lane from a cold, held-in-reset state to a usable state, and back down again. A single `start` pulse launches the bring-up. The block holds the PHY and the lane pipe in reset and brings up the analog supply enable together with both power-good indications. It then leaves power-down test mode, waits out the required hold times, and releases the two resets in a fixed order. It enables receive spread-spectrum tolerance and then polls the lane acknowledge until it falls. Once the lane is up, it hands one fixed configuration write (address 0x0022, data 0x00F5) to an external control-register writer and reports `ready` when that writer signals completion.

A `stop` pulse while ready reverses the reset order and returns the PHY to power-down test mode. Every delay is a number of microseconds turned into clock cycles through the `CLK_HZ` parameter, so the same RTL serves any system clock. If the acknowledge never falls within the poll budget, a sticky timeout flag is raised and the sequence still performs the override write, so software is never left waiting for a `ready` that cannot come.

Top module: `ss_lane_bringup`

## Requirements
- R1: Out of reset the outputs are: PHY reset 1, lane pipe reset (active low) 0, supply enable and both power-good bits 0, test powerdown 1, SRIS enable 0, write request 0, ready 0, timeout flag 0.
- R2: A bring-up begins only from idle. The supply enable and power-good bits rise in a cycle where the PHY reset is 1 and the lane pipe reset is 0.
- R3: Supply enable and both power-good bits rise together. Test powerdown clears no earlier than SETTLE_US microseconds (in clock cycles) after they rise.
- R4: The PHY reset is released no earlier than HOLD_US microseconds after test powerdown clears.
- R5: The PHY reset is released strictly before the lane pipe reset is released. SRIS enable rises strictly after the lane pipe reset is released.
- R6: Once the lane acknowledge falls, the write request rises within POLL_US microseconds plus 6 cycles, and the timeout flag stays 0.
- R7: If the acknowledge stays high for TIMEOUT_US microseconds after SRIS enable, the timeout flag is set and the write request is still issued. The flag is cleared by the next accepted start.
- R8: While the write request is high, address reads 0x0022 and data reads 0x00F5. The request holds until done is sampled. At that edge the request falls and ready rises.
- R9: Stop while ready clears ready and asserts the lane pipe reset at the same edge. The PHY reset is asserted one cycle later. One cycle after that, test powerdown is set and the supply enable, power-good bits and SRIS enable clear.
- R10: Start outside idle and stop outside ready have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin bring-up (idle only) |
| stop_i | input | 1 | Begin shutdown (ready only) |
| lane_ack_i | input | 1 | Lane acknowledge from PHY, high while lane busy |
| wr_done_i | input | 1 | Control-register writer finished the request |
| phy_rst_o | output | 1 | PHY reset, active high |
| lane_rst_n_o | output | 1 | Lane-0 pipe reset, active low |
| ana_pwr_en_o | output | 1 | Analog supply enable |
| pma_stable_o | output | 1 | Analog-section power good |
| pcs_stable_o | output | 1 | Digital-section power good |
| test_pd_o | output | 1 | Test powerdown control |
| rx_sris_en_o | output | 1 | Receive SRIS mode enable |
| wr_req_o | output | 1 | Configuration write request |
| wr_addr_o | output | 16 | Write address, valid with request |
| wr_data_o | output | 16 | Write data, valid with request |
| ready_o | output | 1 | Lane brought up and configured |
| ack_timeout_o | output | 1 | Acknowledge poll timed out |

## Verification
On every cycle the assertions check the ordering relations between the reset, power, powerdown and SRIS outputs. They also check that the write command fields stay stable while the request waits, that ready only follows an accepted completion, and that a ready lane is never in reset. The minimum hold times, the poll latency after the acknowledge falls, the full timeout budget, and the exact one-cycle spacing of the shutdown steps can only be shown by the bench's scenarios. These scenarios randomise acknowledge and completion delays and add directed cases: a timeout, a stray stop during bring-up, and a stray start while ready.

// File: rtl/ssb_pkg.sv
// Shared types for the lane bring-up sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package ssb_pkg;
    typedef enum logic [4:0] {
        ST_IDLE, ST_RST_PHY, ST_RST_LANE, ST_PWR_UP, ST_SETTLE,
        ST_TPD_CLR, ST_HOLD, ST_REL_PHY, ST_REL_LANE, ST_SRIS,
        ST_POLL, ST_POLL_WAIT, ST_WRITE, ST_READY, ST_DN_PHY, ST_DN_TPD
    } seq_state_t;
endpackage

// File: rtl/ssb_down_timer.sv
// Loadable down counter used for every fixed wait of the sequencer.
// Assumes: load_i is a one-cycle pulse; done_o is high while count is zero.
module ssb_down_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] value_i,
    output logic         done_o
);
    logic [W-1:0] cnt_q;

    // Load a new wait length or count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load_i)         cnt_q <= value_i;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign done_o = (cnt_q == '0);
endmodule

// File: rtl/ssb_budget.sv
// Saturating up counter that flags when the acknowledge poll budget is spent.
// Assumes: clear_i and run_i are never high together.
module ssb_budget #(
    parameter int W     = 16,
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    output logic expired_o
);
    localparam logic [W-1:0] LIM = W'(LIMIT);
    logic [W-1:0] cnt_q;

    // Count elapsed poll cycles, stopping at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i)          cnt_q <= '0;
        else if (run_i && cnt_q < LIM)  cnt_q <= cnt_q + 1'b1;
    end

    assign expired_o = (cnt_q >= LIM);
endmodule

// File: rtl/ssb_fsm.sv
// Step sequencer: one output change per step, waits delegated to timers.
// Assumes: timer is loaded in the step before each wait step; all outputs registered.
module ssb_fsm
    import ssb_pkg::*;
#(
    parameter int TW         = 8,
    parameter int SETTLE_CYC = 10,
    parameter int HOLD_CYC   = 10,
    parameter int POLL_CYC   = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic          lane_ack_i,
    input  logic          wr_done_i,
    input  logic          tmr_done_i,
    input  logic          budget_out_i,
    output logic          tmr_load_o,
    output logic [TW-1:0] tmr_value_o,
    output logic          budget_clr_o,
    output logic          budget_run_o,
    output logic          phy_rst_o,
    output logic          lane_rst_n_o,
    output logic          pwr_o,
    output logic          test_pd_o,
    output logic          sris_o,
    output logic          req_o,
    output logic          ready_o,
    output logic          err_o
);
    seq_state_t st_q;

    // Timer and budget controls derived from the current step.
    always_comb begin
        tmr_load_o   = 1'b0;
        tmr_value_o  = '0;
        budget_clr_o = (st_q == ST_SRIS);
        budget_run_o = (st_q == ST_POLL) || (st_q == ST_POLL_WAIT);
        unique case (st_q)
            ST_PWR_UP:  begin tmr_load_o = 1'b1; tmr_value_o = TW'(SETTLE_CYC); end
            ST_TPD_CLR: begin tmr_load_o = 1'b1; tmr_value_o = TW'(HOLD_CYC);   end
            ST_POLL:    begin
                tmr_load_o  = lane_ack_i && !budget_out_i;
                tmr_value_o = TW'(POLL_CYC);
            end
            default: ;
        endcase
    end

    // Advance one step per cycle and update the registered controls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= ST_IDLE;
            phy_rst_o    <= 1'b1;
            lane_rst_n_o <= 1'b0;
            pwr_o        <= 1'b0;
            test_pd_o    <= 1'b1;
            sris_o       <= 1'b0;
            req_o        <= 1'b0;
            ready_o      <= 1'b0;
            err_o        <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE:      if (start_i) begin err_o <= 1'b0; st_q <= ST_RST_PHY; end
                ST_RST_PHY:   begin phy_rst_o <= 1'b1;    st_q <= ST_RST_LANE; end
                ST_RST_LANE:  begin lane_rst_n_o <= 1'b0; st_q <= ST_PWR_UP;   end
                ST_PWR_UP:    begin pwr_o <= 1'b1;        st_q <= ST_SETTLE;   end
                ST_SETTLE:    if (tmr_done_i) st_q <= ST_TPD_CLR;
                ST_TPD_CLR:   begin test_pd_o <= 1'b0;    st_q <= ST_HOLD;     end
                ST_HOLD:      if (tmr_done_i) st_q <= ST_REL_PHY;
                ST_REL_PHY:   begin phy_rst_o <= 1'b0;    st_q <= ST_REL_LANE; end
                ST_REL_LANE:  begin lane_rst_n_o <= 1'b1; st_q <= ST_SRIS;     end
                ST_SRIS:      begin sris_o <= 1'b1;       st_q <= ST_POLL;     end
                ST_POLL: begin
                    if (!lane_ack_i) begin
                        req_o <= 1'b1; st_q <= ST_WRITE;
                    end else if (budget_out_i) begin
                        err_o <= 1'b1; req_o <= 1'b1; st_q <= ST_WRITE;
                    end else begin
                        st_q <= ST_POLL_WAIT;
                    end
                end
                ST_POLL_WAIT: if (tmr_done_i) st_q <= ST_POLL;
                ST_WRITE:     if (wr_done_i) begin req_o <= 1'b0; ready_o <= 1'b1; st_q <= ST_READY; end
                ST_READY:     if (stop_i) begin ready_o <= 1'b0; lane_rst_n_o <= 1'b0; st_q <= ST_DN_PHY; end
                ST_DN_PHY:    begin phy_rst_o <= 1'b1; st_q <= ST_DN_TPD; end
                ST_DN_TPD: begin
                    test_pd_o <= 1'b1;
                    pwr_o     <= 1'b0;
                    sris_o    <= 1'b0;
                    st_q      <= ST_IDLE;
                end
                default:      st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ss_lane_bringup.sv
// Top of the SuperSpeed lane bring-up sequencer: converts microsecond
// delays to cycles and ties the step sequencer to its timers.
// Assumes: CLK_HZ is at least 1 MHz; a control-register writer answers wr_req_o.
module ss_lane_bringup #(
    parameter int          CLK_HZ     = 50_000_000,
    parameter int          SETTLE_US  = 10,
    parameter int          HOLD_US    = 10,
    parameter int          POLL_US    = 40,
    parameter int          TIMEOUT_US = 20_000,
    parameter int          AW         = 16,
    parameter int          DW         = 16,
    parameter logic [15:0] CFG_ADDR   = 16'h0022,
    parameter logic [15:0] CFG_DATA   = 16'h00F5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic          lane_ack_i,
    input  logic          wr_done_i,
    output logic          phy_rst_o,
    output logic          lane_rst_n_o,
    output logic          ana_pwr_en_o,
    output logic          pma_stable_o,
    output logic          pcs_stable_o,
    output logic          test_pd_o,
    output logic          rx_sris_en_o,
    output logic          wr_req_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [DW-1:0] wr_data_o,
    output logic          ready_o,
    output logic          ack_timeout_o
);
    localparam int CYC_US     = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;
    localparam int SETTLE_CYC = SETTLE_US * CYC_US;
    localparam int HOLD_CYC   = HOLD_US * CYC_US;
    localparam int POLL_CYC   = POLL_US * CYC_US;
    localparam int TMO_CYC    = TIMEOUT_US * CYC_US;
    localparam int MAX_WAIT   = (SETTLE_CYC > HOLD_CYC) ?
                                ((SETTLE_CYC > POLL_CYC) ? SETTLE_CYC : POLL_CYC) :
                                ((HOLD_CYC > POLL_CYC) ? HOLD_CYC : POLL_CYC);
    localparam int TW         = $clog2(MAX_WAIT + 1);
    localparam int BW         = $clog2(TMO_CYC + 1);

    logic          tmr_load, tmr_done, bud_clr, bud_run, bud_out, pwr;
    logic [TW-1:0] tmr_value;

    ssb_down_timer #(.W(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load_i(tmr_load),
        .value_i(tmr_value), .done_o(tmr_done)
    );

    ssb_budget #(.W(BW), .LIMIT(TMO_CYC)) u_budget (
        .clk(clk), .rst_n(rst_n), .clear_i(bud_clr),
        .run_i(bud_run), .expired_o(bud_out)
    );

    ssb_fsm #(
        .TW(TW), .SETTLE_CYC(SETTLE_CYC), .HOLD_CYC(HOLD_CYC), .POLL_CYC(POLL_CYC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .lane_ack_i(lane_ack_i), .wr_done_i(wr_done_i),
        .tmr_done_i(tmr_done), .budget_out_i(bud_out),
        .tmr_load_o(tmr_load), .tmr_value_o(tmr_value),
        .budget_clr_o(bud_clr), .budget_run_o(bud_run),
        .phy_rst_o(phy_rst_o), .lane_rst_n_o(lane_rst_n_o), .pwr_o(pwr),
        .test_pd_o(test_pd_o), .sris_o(rx_sris_en_o), .req_o(wr_req_o),
        .ready_o(ready_o), .err_o(ack_timeout_o)
    );

    // Supply enable and both power-good indications share one step.
    assign ana_pwr_en_o = pwr;
    assign pma_stable_o = pwr;
    assign pcs_stable_o = pwr;

    // Command fields are driven only while the request is up.
    assign wr_addr_o = wr_req_o ? AW'(CFG_ADDR) : '0;
    assign wr_data_o = wr_req_o ? DW'(CFG_DATA) : '0;
endmodule

// File: rtl/ss_lane_bringup_chk.sv
// Property checker for the lane bring-up sequencer, bound to the top.
// Assumes: default command address 0x0022 and data 0x00F5.
module ss_lane_bringup_chk #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          stop_i,
    input logic          lane_ack_i,
    input logic          wr_done_i,
    input logic          phy_rst_o,
    input logic          lane_rst_n_o,
    input logic          ana_pwr_en_o,
    input logic          pma_stable_o,
    input logic          pcs_stable_o,
    input logic          test_pd_o,
    input logic          rx_sris_en_o,
    input logic          wr_req_o,
    input logic [AW-1:0] wr_addr_o,
    input logic [DW-1:0] wr_data_o,
    input logic          ready_o,
    input logic          ack_timeout_o
);
    // R2: supplies come up only with both resets held
    a_r2_power_under_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ana_pwr_en_o) |-> phy_rst_o && !lane_rst_n_o);

    // R3: leaving powerdown needs supplies good and PHY still in reset
    a_r3_tpd_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(test_pd_o) |-> ana_pwr_en_o && pma_stable_o && pcs_stable_o && phy_rst_o);

    // R5: release order
    a_r5_phy_before_lane: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phy_rst_o) |-> !lane_rst_n_o);
    a_r5_lane_after_phy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lane_rst_n_o) |-> !phy_rst_o);
    a_r5_sris_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_sris_en_o) |-> lane_rst_n_o && !phy_rst_o);

    // R6: request follows a low acknowledge or a timeout
    a_r6_req_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_req_o) |-> !$past(lane_ack_i) || ack_timeout_o);

    // R8: command fields and handshake
    a_r8_cmd_fields: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o |-> wr_addr_o == AW'(16'h0022) && wr_data_o == DW'(16'h00F5));
    a_r8_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o && !wr_done_i |=> wr_req_o);
    a_r8_ready_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(wr_done_i) && $past(wr_req_o));

    // R9: shutdown order and a ready lane is never in reset
    a_r9_phy_after_lane: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phy_rst_o) |-> !lane_rst_n_o);
    a_r9_tpd_last: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(test_pd_o) |-> phy_rst_o && !lane_rst_n_o);
    a_r9_ready_live: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> !phy_rst_o && lane_rst_n_o && !test_pd_o);

    // R10: start while ready changes nothing
    a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o && start_i && !stop_i |=> ready_o);
endmodule

bind ss_lane_bringup ss_lane_bringup_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/ss_lane_bringup_bench.sv
// Bench: 50 MHz clock; CLK_HZ set to 1 MHz so one cycle stands for one microsecond.
module ss_lane_bringup_bench;
    localparam int SETTLE = 10, HOLD = 10, POLL = 40, TMO = 20000;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, stop = 1'b0, ack = 1'b1, done = 1'b0;
    logic phy_rst, lane_rst_n, ana_pwr, pma_ok, pcs_ok, test_pd, sris, req, ready, tmo;
    logic [15:0] addr, data;

    ss_lane_bringup #(.CLK_HZ(1_000_000), .SETTLE_US(SETTLE), .HOLD_US(HOLD),
                      .POLL_US(POLL), .TIMEOUT_US(TMO)) u_ss_lane_bringup (
        .clk(clk), .rst_n(rst_n), .start_i(start), .stop_i(stop),
        .lane_ack_i(ack), .wr_done_i(done), .phy_rst_o(phy_rst),
        .lane_rst_n_o(lane_rst_n), .ana_pwr_en_o(ana_pwr), .pma_stable_o(pma_ok),
        .pcs_stable_o(pcs_ok), .test_pd_o(test_pd), .rx_sris_en_o(sris),
        .wr_req_o(req), .wr_addr_o(addr), .wr_data_o(data), .ready_o(ready),
        .ack_timeout_o(tmo)
    );

    always #10 clk = ~clk;

    int cyc = 0, n_chk = 0, n_fail = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Edge time stamps taken by the monitor
    int t_pwr, t_tpd_fall, t_phy_fall, t_lane_rise, t_sris, t_lane_fall, t_phy_rise, t_tpd_rise;
    logic p_pwr = 0, p_tpd = 1, p_phy = 1, p_lane = 0, p_sris = 0;
    always @(negedge clk) begin
        if (!p_pwr && ana_pwr)     t_pwr = cyc;
        if (p_tpd && !test_pd)     t_tpd_fall = cyc;
        if (!p_tpd && test_pd)     t_tpd_rise = cyc;
        if (p_phy && !phy_rst)     t_phy_fall = cyc;
        if (!p_phy && phy_rst)     t_phy_rise = cyc;
        if (!p_lane && lane_rst_n) t_lane_rise = cyc;
        if (p_lane && !lane_rst_n) t_lane_fall = cyc;
        if (!p_sris && sris)       t_sris = cyc;
        p_pwr = ana_pwr; p_tpd = test_pd; p_phy = phy_rst; p_lane = lane_rst_n; p_sris = sris;
    end

    function automatic int exp_addr(); return 32'h0022; endfunction
    function automatic int exp_data(); return 32'h00F5; endfunction
    function automatic int poll_bound(); return POLL + 6; endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    // One bring-up; ack_delay < 0 keeps the acknowledge high
    task automatic bringup(input int ack_delay, input int done_delay, input bit stray_stop);
        int ts, ta, tr;
        ta = 0;
        ack = 1'b1;
        pulse_start();
        @(negedge clk);
        chk(tmo == 1'b0, "R7 flag cleared by start", tmo, 0);
        while (!ana_pwr) @(negedge clk);
        chk(phy_rst && !lane_rst_n, "R2 resets held at power-up", {phy_rst, lane_rst_n}, 2);
        chk(pma_ok && pcs_ok, "R3 power bits together", {pma_ok, pcs_ok}, 3);
        if (stray_stop) begin
            stop = 1'b1; @(negedge clk) stop = 1'b0;
        end
        while (!sris) @(negedge clk);
        ts = cyc;
        if (ack_delay >= 0) begin
            repeat (ack_delay) @(negedge clk);
            ack = 1'b0; ta = cyc;
        end
        while (!req) @(negedge clk);
        tr = cyc;
        chk(32'(addr) == exp_addr(), "R8 address", addr, exp_addr());
        chk(32'(data) == exp_data(), "R8 data", data, exp_data());
        if (ack_delay >= 0) begin
            chk(tr - ta <= poll_bound(), "R6 poll latency", tr - ta, poll_bound());
            chk(tmo == 1'b0, "R6 no timeout", tmo, 0);
        end else begin
            chk(tr - ts >= TMO, "R7 timeout budget", tr - ts, TMO);
            chk(tmo == 1'b1, "R7 timeout flag", tmo, 1);
        end
        repeat (done_delay) @(negedge clk);
        chk(req && !ready, "R8 request holds", {req, ready}, 2);
        done = 1'b1;
        @(negedge clk) done = 1'b0;
        chk(ready && !req, "R8 ready on done", {ready, req}, 2);
        @(negedge clk);
        chk(t_tpd_fall - t_pwr >= SETTLE, "R3 settle time", t_tpd_fall - t_pwr, SETTLE);
        chk(t_phy_fall - t_tpd_fall >= HOLD, "R4 hold time", t_phy_fall - t_tpd_fall, HOLD);
        chk(t_lane_rise > t_phy_fall, "R5 lane after phy", t_lane_rise, t_phy_fall + 1);
        chk(t_sris > t_lane_rise, "R5 sris after lane", t_sris, t_lane_rise + 1);
    endtask

    task automatic shutdown();
        @(negedge clk) stop = 1'b1;
        @(negedge clk) stop = 1'b0;
        chk(!ready && !lane_rst_n && !phy_rst, "R9 stop edge", {ready, lane_rst_n, phy_rst}, 0);
        repeat (3) @(negedge clk);
        chk(t_phy_rise == t_lane_fall + 1, "R9 phy reset next", t_phy_rise, t_lane_fall + 1);
        chk(t_tpd_rise == t_phy_rise + 1, "R9 powerdown last", t_tpd_rise, t_phy_rise + 1);
        chk(!ana_pwr && !sris && test_pd, "R9 supplies off", {ana_pwr, sris, test_pd}, 1);
        ack = 1'b1;
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(phy_rst && !lane_rst_n && !ana_pwr && !pma_ok && !pcs_ok && test_pd && !sris,
            "R1 reset outputs", {phy_rst, lane_rst_n, ana_pwr, test_pd, sris}, 5'b10010);
        chk(!req && !ready && !tmo, "R1 handshake idle", {req, ready, tmo}, 0);

        // R10: stop while idle has no effect
        @(negedge clk) stop = 1'b1;
        @(negedge clk) stop = 1'b0;
        repeat (3) @(negedge clk);
        chk(phy_rst && test_pd && !ana_pwr, "R10 stop ignored in idle", {phy_rst, test_pd, ana_pwr}, 6);

        // Directed: immediate acknowledge, immediate completion
        bringup(0, 0, 1'b0);
        // R10: start while ready has no effect
        pulse_start();
        repeat (2) @(negedge clk);
        chk(ready && !phy_rst && lane_rst_n, "R10 start ignored in ready", {ready, phy_rst, lane_rst_n}, 5);
        shutdown();

        // Directed: stray stop during bring-up (R10)
        bringup(3, 1, 1'b1);
        chk(ready == 1'b1, "R10 stray stop ignored", ready, 1);
        shutdown();

        // Random acknowledge and completion delays
        for (int i = 0; i < 5; i++) begin
            bringup(int'($urandom_range(0, 300)), int'($urandom_range(0, 6)), 1'b0);
            shutdown();
        end

        // Directed: acknowledge never falls (R7), then recovery clears the flag
        bringup(-1, 2, 1'b0);
        shutdown();
        bringup(POLL, 0, 1'b0);
        shutdown();

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule